// File: doc/BRIEF.md
# Two-Wire Serial Bus Monitor

This block watches the clock and data lines of a two-wire serial bus (I2C) without ever driving them. Both lines are oversampled by the system clock through a synchronizer. The block finds START and STOP conditions and gathers each nine-bit transfer into a byte plus an acknowledge bit. It then reports what it saw as a stream of events on a single valid-strobed output.

A free-running sample counter stamps every event. Condition and acknowledge events carry one sample index. Byte events carry the index where their first payload bit was clocked and the index just before the acknowledge bit. The first byte after a START is an address, tagged read or write from its least significant bit. Every byte after it until the next STOP or START is a data byte with that same direction. A logic analyser back end, a bus trace buffer or a protocol checker consumes the event stream.

Top module: `i2cmon_top`

## Requirements
- R1: SDA going 1 to 0 while SCL is high emits a START event (kind 0) with t0 = t1 = its sample index, and opens the address phase with an empty bit counter and shift register.
- R2: SDA going 0 to 1 while SCL is high emits a STOP event (kind 1), returns to idle and forgets the transfer direction, so SCL pulses that follow without a START produce no event.
- R3: SDA is taken only on an SCL rising edge, most significant bit first; SDA changes while SCL is low do not alter the byte.
- R4: The byte after a START is reported after its ninth SCL rise as kind 2 (write, bit 0 was 0) or kind 3 (read, bit 0 was 1), with bit 0 of the reported value forced to zero.
- R5: Later bytes are reported as kind 4 when the latched direction is write and kind 5 when it is read, with all eight bits as received.
- R6: The flag ev_nack carries SDA at the ninth rise (1 = not acknowledged). The cycle after each byte event, an acknowledge event (kind 6, value 0, same flag) follows, with t0 = t1 = the ninth rise's sample index.
- R7: A byte event has t0 = sample index of its first SCL rise and t1 = sample index of its ninth rise minus one.
- R8: The counter reads 0 in the first cycle after reset and adds one per clock. A line change first captured at the clock edge that ends counter value c is stamped c+2. Its event is valid in the cycle where the counter reads c+3.
- R9: A START that arrives in the middle of a byte drops the partial byte without an event and begins a fresh address phase.
- R10: SCL pulses seen while idle, before any START, produce no event.
- R11: ev_valid is 0 during reset. The samples held in the synchronizer at reset, and the first real sample, make no edge decision, so lines held at SCL=1, SDA=0 through reset produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one line sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| ev_valid | output | 1 | One-cycle strobe for an event |
| ev_kind | output | 3 | 0 START, 1 STOP, 2 addr write, 3 addr read, 4 data write, 5 data read, 6 acknowledge |
| ev_byte | output | 8 | Byte value (address with bit 0 cleared) |
| ev_nack | output | 1 | Acknowledge bit level, 1 = not acknowledged |
| ev_t0 | output | 32 | Sample index where the event began |
| ev_t1 | output | 32 | Sample index where the event ended |

## Verification
The hardest case to reach is a repeated START that lands after only a few payload bits. Reaching it needs an SDA rise with SCL low, an extra SCL rise that the monitor still counts as a payload bit, and then an SDA fall while SCL stays high. The bench builds this sequence out of its bit and condition tasks, then expects two START events with no byte between them. A second awkward case is the power-up pattern. The lines are held at SCL high and SDA low through reset, which would look like a START if the synchronizer's reset value took part in edge detection. The bench then checks that no event appears.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    parameter int STAMP_W = 32;
    parameter int BYTE_W  = 8;

    typedef enum logic [2:0] {
        EV_START   = 3'd0,
        EV_STOP    = 3'd1,
        EV_ADDR_WR = 3'd2,
        EV_ADDR_RD = 3'd3,
        EV_DATA_WR = 3'd4,
        EV_DATA_RD = 3'd5,
        EV_ACK     = 3'd6
    } ev_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        ev_kind_e              kind;
        logic [BYTE_W-1:0]     data;
        logic                  nack;
        logic [STAMP_W-1:0]    t0;
        logic [STAMP_W-1:0]    t1;
    } ev_rec_t;

    function automatic ev_kind_e byte_kind(input logic is_addr, input logic rd);
        if (is_addr) return rd ? EV_ADDR_RD : EV_ADDR_WR;
        return rd ? EV_DATA_RD : EV_DATA_WR;
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cmon_framer.sv
module i2cmon_framer
    import i2cmon_pkg::*;
#(
    parameter int WARM_CYC = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               s_scl,
    input  logic               s_sda,
    input  logic [STAMP_W-1:0] now,
    output logic               cond_v,
    output ev_rec_t            cond_ev,
    output logic               byte_v,
    output ev_rec_t            byte_ev,
    output ev_rec_t            ack_ev
);
    localparam int WARM_W = $clog2(WARM_CYC + 1);
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    logic [WARM_W-1:0]  warm;
    logic               p_scl, p_sda;
    phase_e             phase;
    logic [CNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]  shreg;
    logic [STAMP_W-1:0] t_first;
    logic               dir_rd;

    logic armed, start_c, rise_c, stop_c, done_c;

    always_comb begin
        armed   = (warm == WARM_W'(WARM_CYC));
        start_c = armed & s_scl & p_sda & ~s_sda;
        rise_c  = armed & ~p_scl & s_scl & ~start_c;
        stop_c  = armed & s_scl & ~p_sda & s_sda & ~rise_c;
        done_c  = rise_c & (phase != PH_IDLE) & (bitcnt == CNT_W'(BYTE_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            warm    <= '0;
            p_scl   <= 1'b1;
            p_sda   <= 1'b1;
            phase   <= PH_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            t_first <= '0;
            dir_rd  <= 1'b0;
        end else begin
            p_scl <= s_scl;
            p_sda <= s_sda;
            if (!armed) warm <= warm + 1'b1;
            if (start_c) begin
                phase  <= PH_ADDR;
                bitcnt <= '0;
                shreg  <= '0;
            end else if (rise_c && phase != PH_IDLE) begin
                if (bitcnt == '0) t_first <= now;
                if (done_c) begin
                    bitcnt <= '0;
                    if (phase == PH_ADDR) begin
                        dir_rd <= shreg[0];
                        phase  <= PH_DATA;
                    end
                end else begin
                    shreg  <= {shreg[BYTE_W-2:0], s_sda};
                    bitcnt <= bitcnt + 1'b1;
                end
            end else if (stop_c) begin
                phase  <= PH_IDLE;
                dir_rd <= 1'b0;
                bitcnt <= '0;
            end
        end
    end

    always_comb begin
        cond_v       = start_c | stop_c;
        cond_ev.kind = start_c ? EV_START : EV_STOP;
        cond_ev.data = '0;
        cond_ev.nack = 1'b0;
        cond_ev.t0   = now;
        cond_ev.t1   = now;

        byte_v       = done_c;
        byte_ev.kind = byte_kind(phase == PH_ADDR,
                                 (phase == PH_ADDR) ? shreg[0] : dir_rd);
        byte_ev.data = (phase == PH_ADDR) ? {shreg[BYTE_W-1:1], 1'b0} : shreg;
        byte_ev.nack = s_sda;
        byte_ev.t0   = t_first;
        byte_ev.t1   = now - 1'b1;

        ack_ev.kind  = EV_ACK;
        ack_ev.data  = '0;
        ack_ev.nack  = s_sda;
        ack_ev.t0    = now;
        ack_ev.t1    = now;
    end
endmodule

// File: rtl/i2cmon_report.sv
module i2cmon_report
    import i2cmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cond_v,
    input  ev_rec_t cond_ev,
    input  logic    byte_v,
    input  ev_rec_t byte_ev,
    input  ev_rec_t ack_ev,
    output logic    out_v,
    output ev_rec_t out_ev
);
    logic    ack_pend, cond_pend;
    ev_rec_t ack_hold, cond_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v     <= 1'b0;
            out_ev    <= '0;
            ack_pend  <= 1'b0;
            cond_pend <= 1'b0;
            ack_hold  <= '0;
            cond_hold <= '0;
        end else begin
            out_v <= 1'b0;
            if (ack_pend) begin
                out_v    <= 1'b1;
                out_ev   <= ack_hold;
                ack_pend <= 1'b0;
                if (cond_v) begin
                    cond_pend <= 1'b1;
                    cond_hold <= cond_ev;
                end
            end else if (cond_pend) begin
                out_v     <= 1'b1;
                out_ev    <= cond_hold;
                cond_pend <= cond_v;
                cond_hold <= cond_ev;
            end else if (byte_v) begin
                out_v    <= 1'b1;
                out_ev   <= byte_ev;
                ack_pend <= 1'b1;
                ack_hold <= ack_ev;
            end else if (cond_v) begin
                out_v  <= 1'b1;
                out_ev <= cond_ev;
            end
        end
    end
endmodule

// File: rtl/i2cmon_top.sv
module i2cmon_top
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               ev_valid,
    output logic [2:0]         ev_kind,
    output logic [BYTE_W-1:0]  ev_byte,
    output logic               ev_nack,
    output logic [STAMP_W-1:0] ev_t0,
    output logic [STAMP_W-1:0] ev_t1
);
    localparam int WARM_CYC = SYNC_STAGES + 1;

    logic [1:0]         lines;
    logic [STAMP_W-1:0] samp_cnt;
    logic               cond_v, byte_v;
    ev_rec_t            cond_ev, byte_ev, ack_ev, out_ev;

    always_ff @(posedge clk) begin
        if (rst) samp_cnt <= '0;
        else     samp_cnt <= samp_cnt + 1'b1;
    end

    i2cmon_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (lines)
    );

    i2cmon_framer #(.WARM_CYC(WARM_CYC)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .s_scl   (lines[1]),
        .s_sda   (lines[0]),
        .now     (samp_cnt),
        .cond_v  (cond_v),
        .cond_ev (cond_ev),
        .byte_v  (byte_v),
        .byte_ev (byte_ev),
        .ack_ev  (ack_ev)
    );

    i2cmon_report u_report (
        .clk     (clk),
        .rst     (rst),
        .cond_v  (cond_v),
        .cond_ev (cond_ev),
        .byte_v  (byte_v),
        .byte_ev (byte_ev),
        .ack_ev  (ack_ev),
        .out_v   (ev_valid),
        .out_ev  (out_ev)
    );

    assign ev_kind = out_ev.kind;
    assign ev_byte = out_ev.data;
    assign ev_nack = out_ev.nack;
    assign ev_t0   = out_ev.t0;
    assign ev_t1   = out_ev.t1;
endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk
    import i2cmon_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ev_valid,
    input logic [2:0]         ev_kind,
    input logic [BYTE_W-1:0]  ev_byte,
    input logic [STAMP_W-1:0] ev_t0,
    input logic [STAMP_W-1:0] ev_t1
);
    logic is_byte, is_addr, is_cond;
    assign is_byte = (ev_kind >= 3'd2) && (ev_kind <= 3'd5);
    assign is_addr = (ev_kind == 3'd2) || (ev_kind == 3'd3);
    assign is_cond = (ev_kind == 3'd0) || (ev_kind == 3'd1);

    AST_COND_POINT_STAMP: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && is_cond) |-> (ev_t0 == ev_t1)); // R1

    AST_ADDR_LSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && is_addr) |-> (ev_byte[0] == 1'b0)); // R4

    AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && is_byte) |=> (ev_valid && ev_kind == 3'd6)); // R6

    AST_ACK_STAMP_NEXT: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == 3'd6) |->
            ($past(ev_valid) && ev_t0 == ev_t1 && ev_t0 == $past(ev_t1) + 1'b1)); // R7

    AST_BYTE_SPAN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && is_byte) |-> (ev_t1 > ev_t0)); // R7

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !ev_valid); // R11
endmodule

bind i2cmon_top i2cmon_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind),
    .ev_byte  (ev_byte),
    .ev_t0    (ev_t0),
    .ev_t1    (ev_t1)
);

// File: tb/i2cmon_top_tb_top.sv
module i2cmon_top_tb_top;
    localparam int HOLD = 4;
    localparam int NVEC = 4;
    // {address byte, data byte, address nack, data nack}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'hA0, 8'h5A, 1'b0, 1'b0},
        {8'hA1, 8'hC3, 1'b0, 1'b1},
        {8'hFF, 8'h00, 1'b1, 1'b0},
        {8'h00, 8'h81, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda = 1'b1;
    logic        ev_valid;
    logic [2:0]  ev_kind;
    logic [7:0]  ev_byte;
    logic        ev_nack;
    logic [31:0] ev_t0, ev_t1;

    always #4 clk = ~clk;

    i2cmon_top dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
        .ev_nack(ev_nack), .ev_t0(ev_t0), .ev_t1(ev_t1)
    );

    logic [31:0] bc = 0;
    always @(posedge clk) bc <= rst ? 32'd0 : bc + 1;

    logic [75:0] cap_q  [128];
    logic [31:0] cap_bc [128];
    int          cap_n = 0;
    always @(negedge clk) begin
        if (!rst && ev_valid && cap_n < 128) begin
            cap_q[cap_n]  <= {ev_kind, ev_byte, ev_nack, ev_t0, ev_t1};
            cap_bc[cap_n] <= bc;
            cap_n         <= cap_n + 1;
        end
    end

    logic [75:0] exp_q [32];
    int exp_n, base;
    int n_chk = 0, n_fail = 0;

    function automatic logic [75:0] ev_pack(input logic [2:0] k, input logic [7:0] d,
                                            input logic n, input logic [31:0] a,
                                            input logic [31:0] b);
        return {k, d, n, a, b};
    endfunction

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd0:        return "R1 R8";
            3'd1:        return "R2";
            3'd2, 3'd3:  return "R3 R4 R7";
            3'd4, 3'd5:  return "R3 R5 R7";
            default:     return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [79:0] act, input logic [79:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [75:0] e);
        exp_q[exp_n] = e;
        exp_n++;
    endtask

    task automatic begin_case();
        exp_n = 0;
        base  = cap_n;
    endtask

    task automatic send_start(output logic [31:0] st);
        sda = 1'b1; tick(HOLD);
        scl = 1'b1; tick(HOLD);
        sda = 1'b0; st = bc + 2; tick(HOLD);
        scl = 1'b0; tick(HOLD);
    endtask

    task automatic send_stop(output logic [31:0] st);
        sda = 1'b0; tick(HOLD);
        scl = 1'b1; tick(HOLD);
        sda = 1'b1; st = bc + 2; tick(HOLD);
    endtask

    // Toggles SDA while SCL is low before settling it (R3).
    task automatic send_bit(input logic b, output logic [31:0] rise);
        sda = ~b; tick(2);
        sda = b;  tick(HOLD);
        scl = 1'b1; rise = bc + 2; tick(HOLD);
        scl = 1'b0; tick(HOLD);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ackb,
                             output logic [31:0] t_first, output logic [31:0] t_ack);
        logic [31:0] r;
        t_first = 0;
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i], r);
            if (i == 7) t_first = r;
        end
        send_bit(ackb, t_ack);
    endtask

    task automatic finish_case(input string cnt_tag);
        int got;
        tick(12);
        got = cap_n - base;
        check(got == exp_n, cnt_tag, 80'(got), 80'(exp_n));
        for (int i = 0; i < exp_n; i++) begin
            if (i < got)
                check(cap_q[base+i] == exp_q[i], tag_of(exp_q[i][75:73]),
                      80'(cap_q[base+i]), 80'(exp_q[i]));
        end
        if (exp_n > 0 && got > 0)
            check(cap_bc[base] == exp_q[0][31:0] + 1, "R8",
                  80'(cap_bc[base]), 80'(exp_q[0][31:0] + 1));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] st, sp, ta, tk, td, tdk, st2;
        logic [7:0]  ab, db;
        logic        an, dn;

        // R11: reset with SCL high, SDA low held through and after reset
        rst = 1'b1; scl = 1'b1; sda = 1'b0;
        tick(5);
        check(ev_valid == 1'b0, "R11", 80'(ev_valid), 80'(0));
        rst = 1'b0;
        base = cap_n; exp_n = 0;
        tick(20);
        scl = 1'b0; tick(HOLD);
        sda = 1'b1; tick(HOLD);
        scl = 1'b1; tick(HOLD);
        finish_case("R11");

        // Table walk: R1 R3 R4 R5 R6 R7 R8 R2
        for (int v = 0; v < NVEC; v++) begin
            ab = VEC[v][17:10]; db = VEC[v][9:2]; an = VEC[v][1]; dn = VEC[v][0];
            begin_case();
            tick(8);
            send_start(st);
            push(ev_pack(3'd0, 8'h00, 1'b0, st, st));
            send_byte(ab, an, ta, tk);
            push(ev_pack(ab[0] ? 3'd3 : 3'd2, {ab[7:1], 1'b0}, an, ta, tk - 1));
            push(ev_pack(3'd6, 8'h00, an, tk, tk));
            send_byte(db, dn, td, tdk);
            push(ev_pack(ab[0] ? 3'd5 : 3'd4, db, dn, td, tdk - 1));
            push(ev_pack(3'd6, 8'h00, dn, tdk, tdk));
            send_stop(sp);
            push(ev_pack(3'd1, 8'h00, 1'b0, sp, sp));
            finish_case("R1 R2 count");
        end

        // R10 and R2: clock pulses after a STOP without a START are ignored
        begin_case();
        scl = 1'b0; tick(HOLD);
        send_byte(8'hA5, 1'b0, ta, tk);
        sda = 1'b1; tick(HOLD);
        scl = 1'b1; tick(HOLD);
        finish_case("R2 R10");

        // R9: repeated START after four payload bits drops the partial byte
        begin_case();
        send_start(st);
        push(ev_pack(3'd0, 8'h00, 1'b0, st, st));
        send_bit(1'b1, ta); send_bit(1'b0, ta); send_bit(1'b1, ta); send_bit(1'b1, ta);
        send_start(st2);
        push(ev_pack(3'd0, 8'h00, 1'b0, st2, st2));
        send_byte(8'h53, 1'b0, ta, tk);
        push(ev_pack(3'd3, 8'h52, 1'b0, ta, tk - 1));
        push(ev_pack(3'd6, 8'h00, 1'b0, tk, tk));
        send_stop(sp);
        push(ev_pack(3'd1, 8'h00, 1'b0, sp, sp));
        finish_case("R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule